// File: doc/BRIEF.md
# Gate Descriptor Validation Unit

This unit checks a gate descriptor that a control transfer has fetched, together with the descriptor its destination selector names. It decides whether the transfer may proceed or which fault must be raised. It also reports facts the later transfer logic needs: the kind of gate, whether the gate is present, whether it is in the legacy narrow layout, how wide the stack pushes are, and how many bytes of parameters a call gate copies. Privilege comparison, descriptor fetching, stack switching and the copy itself belong to other blocks.

Both descriptors enter as one beat on a valid/ready input stream, and the verdict leaves as one beat on a valid/ready output stream. The unit holds a single result register. The input is ready whenever that register is empty or is being drained in the same cycle. An accepted beat appears on the output one cycle later. While the output is valid and not accepted, every output field stays unchanged and no new input is taken.

Top module: `gdv_top`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A beat is accepted when `in_valid && in_ready` at a clock edge, and its result is on the outputs with `out_valid` high after that edge. While `out_valid && !out_ready`, all result outputs hold their values.
- R2: If the gate's present bit (bit 47) is 0, the result is `fault_valid=1`, `fault_vec=11`, whatever else is wrong with either descriptor.
- R3: If the gate is present and its system bit (bit 44) is 1, the result is `fault_valid=1`, `fault_vec=13`.
- R4: The gate type (bits 43:40) decodes as follows. 4 and 12 give call (`gate_kind=1`). 6 and 14 give interrupt (2). 7 and 15 give trap (3). 5 gives task (4). Any other value gives none (0), and a present gate with system bit 0 and type none faults with vector 13.
- R5: For a call, interrupt or trap gate that passes R2 to R4, the destination must be a code segment: destination bit 44 = 1 and bit 43 = 1. Otherwise the result faults with vector 13.
- R6: For a task gate that passes R2 and R3, the destination must be a task state segment. That means destination bit 44 = 0 and destination type (bits 43:40) is one of 1, 3, 9 or 11. Otherwise the result faults with vector 13.
- R7: `legacy` is 1 exactly when gate bits 63:48 are all zero.
- R8: `push_wide` (32-bit pushes) equals gate type bit 3 (bit 43). A value of 0 means 16-bit pushes.
- R9: For a call gate, `copy_bytes` is the count in bits 36:32 times 2 if `legacy`, else times 4. For every other kind it is 0.
- R10: `dest_sel` is gate bits 31:16. `dest_off` is {bits 63:48, bits 15:0}, forced to 0 for a task gate.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.
- R12: `present` reflects gate bit 47. When no fault applies, `fault_valid=0` and `fault_vec=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| gate_desc | input | 64 | Gate descriptor |
| dest_desc | input | 64 | Descriptor named by the gate's selector |
| out_valid | output | 1 | Result beat offered |
| out_ready | input | 1 | Consumer takes the result |
| fault_valid | output | 1 | Transfer must fault |
| fault_vec | output | 8 | Fault vector (11 or 13), 0 when no fault |
| gate_kind | output | 3 | 0 none, 1 call, 2 interrupt, 3 trap, 4 task |
| present | output | 1 | Gate present bit |
| legacy | output | 1 | Gate uses the narrow layout |
| push_wide | output | 1 | 1 for 32-bit pushes, 0 for 16-bit |
| copy_bytes | output | 7 | Parameter bytes to copy |
| dest_sel | output | 16 | Destination selector |
| dest_off | output | 32 | Destination offset |

## Verification
The bench builds the unit with its default count width of five bits. That width lets the largest count, 31, reach the top of the 7-bit `copy_bytes` range: 124 bytes for a wide call and 62 for a legacy call. The default vectors 11 and 13 keep the two fault codes distinct. Directed beats cover every fault priority pair. Random beats are driven under random back-pressure and random input gaps, so holding the output and blocking the input are exercised together with the decode.

// File: rtl/gdv_pkg.sv
package gdv_pkg;
  typedef enum logic [2:0] {
    GK_NONE = 3'd0,
    GK_CALL = 3'd1,
    GK_INTR = 3'd2,
    GK_TRAP = 3'd3,
    GK_TASK = 3'd4
  } gate_kind_e;

  // access byte field positions inside a 64-bit descriptor
  localparam int unsigned TYPE_LSB  = 40;
  localparam int unsigned SYS_BIT   = 44;
  localparam int unsigned PRES_BIT  = 47;
  localparam int unsigned WC_LSB    = 32;
  localparam int unsigned UPPER_LSB = 48;
endpackage

// File: rtl/gdv_gate_decode.sv
module gdv_gate_decode
  import gdv_pkg::*;
#(
  parameter int unsigned WC_W = 5,
  localparam int unsigned CB_W = WC_W + 2
) (
  input  logic [63:0]     gate,
  output gate_kind_e      kind,
  output logic            present,
  output logic            sys_bit,
  output logic            legacy,
  output logic            push_wide,
  output logic [CB_W-1:0] copy_bytes,
  output logic [15:0]     sel,
  output logic [31:0]     off
);
  logic [3:0]      typ;
  logic [WC_W-1:0] count;

  assign typ       = gate[TYPE_LSB +: 4];
  assign count     = gate[WC_LSB +: WC_W];
  assign present   = gate[PRES_BIT];
  assign sys_bit   = gate[SYS_BIT];
  assign legacy    = (gate[UPPER_LSB +: 16] == 16'h0000);
  assign push_wide = typ[3];
  assign sel       = gate[31:16];

  always_comb begin
    unique case (typ)
      4'h4, 4'hC: kind = GK_CALL;
      4'h6, 4'hE: kind = GK_INTR;
      4'h7, 4'hF: kind = GK_TRAP;
      4'h5:       kind = GK_TASK;
      default:    kind = GK_NONE;
    endcase
  end

  always_comb begin
    if (kind != GK_CALL)  copy_bytes = '0;
    else if (legacy)      copy_bytes = {1'b0, count, 1'b0};
    else                  copy_bytes = {count, 2'b00};
  end

  always_comb begin
    if (kind == GK_TASK) off = '0;
    else                 off = {gate[UPPER_LSB +: 16], gate[15:0]};
  end
endmodule

// File: rtl/gdv_dest_check.sv
module gdv_dest_check
  import gdv_pkg::*;
(
  input  logic [63:0] dest,
  input  gate_kind_e  kind,
  output logic        dest_ok
);
  logic [3:0] dtyp;
  logic       is_code;
  logic       is_tss;

  assign dtyp    = dest[TYPE_LSB +: 4];
  assign is_code = dest[SYS_BIT] && dtyp[3];
  // available or busy task state segment, either layout
  assign is_tss  = !dest[SYS_BIT] && dtyp[0] && !dtyp[2];

  always_comb begin
    unique case (kind)
      GK_CALL, GK_INTR, GK_TRAP: dest_ok = is_code;
      GK_TASK:                   dest_ok = is_tss;
      default:                   dest_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/gdv_fault_arb.sv
module gdv_fault_arb
  import gdv_pkg::*;
#(
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned NP_VEC = 11,
  parameter int unsigned GP_VEC = 13
) (
  input  logic             present,
  input  logic             sys_bit,
  input  gate_kind_e       kind,
  input  logic             dest_ok,
  output logic             fault_valid,
  output logic [VEC_W-1:0] fault_vec
);
  always_comb begin
    fault_valid = 1'b1;
    if (!present)              fault_vec = VEC_W'(NP_VEC);
    else if (sys_bit)          fault_vec = VEC_W'(GP_VEC);
    else if (kind == GK_NONE)  fault_vec = VEC_W'(GP_VEC);
    else if (!dest_ok)         fault_vec = VEC_W'(GP_VEC);
    else begin
      fault_valid = 1'b0;
      fault_vec   = '0;
    end
  end
endmodule

// File: rtl/gdv_top.sv
module gdv_top
  import gdv_pkg::*;
#(
  parameter int unsigned WC_W   = 5,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned NP_VEC = 11,
  parameter int unsigned GP_VEC = 13,
  localparam int unsigned CB_W  = WC_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:0]      gate_desc,
  input  logic [63:0]      dest_desc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             fault_valid,
  output logic [VEC_W-1:0] fault_vec,
  output logic [2:0]       gate_kind,
  output logic             present,
  output logic             legacy,
  output logic             push_wide,
  output logic [CB_W-1:0]  copy_bytes,
  output logic [15:0]      dest_sel,
  output logic [31:0]      dest_off
);
  typedef struct packed {
    logic             fv;
    logic [VEC_W-1:0] vec;
    gate_kind_e       kind;
    logic             pres;
    logic             leg;
    logic             pw;
    logic [CB_W-1:0]  cb;
    logic [15:0]      sel;
    logic [31:0]      off;
  } result_t;

  gate_kind_e      d_kind;
  logic            d_pres, d_sys, d_leg, d_pw, d_ok, d_fv;
  logic [CB_W-1:0] d_cb;
  logic [15:0]     d_sel;
  logic [31:0]     d_off;
  logic [VEC_W-1:0] d_vec;
  result_t         res_d, res_q;
  logic            ov_q;
  logic            accept;

  gdv_gate_decode #(.WC_W(WC_W)) u_dec (
    .gate(gate_desc), .kind(d_kind), .present(d_pres), .sys_bit(d_sys),
    .legacy(d_leg), .push_wide(d_pw), .copy_bytes(d_cb), .sel(d_sel), .off(d_off)
  );

  gdv_dest_check u_dst (
    .dest(dest_desc), .kind(d_kind), .dest_ok(d_ok)
  );

  gdv_fault_arb #(.VEC_W(VEC_W), .NP_VEC(NP_VEC), .GP_VEC(GP_VEC)) u_arb (
    .present(d_pres), .sys_bit(d_sys), .kind(d_kind), .dest_ok(d_ok),
    .fault_valid(d_fv), .fault_vec(d_vec)
  );

  assign res_d = '{fv: d_fv, vec: d_vec, kind: d_kind, pres: d_pres, leg: d_leg,
                   pw: d_pw, cb: d_cb, sel: d_sel, off: d_off};

  assign in_ready = !ov_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      res_q <= '0;
    end else begin
      if (in_ready) ov_q <= in_valid;
      if (accept)   res_q <= res_d;
    end
  end

  assign out_valid   = ov_q;
  assign fault_valid = res_q.fv;
  assign fault_vec   = res_q.vec;
  assign gate_kind   = res_q.kind;
  assign present     = res_q.pres;
  assign legacy      = res_q.leg;
  assign push_wide   = res_q.pw;
  assign copy_bytes  = res_q.cb;
  assign dest_sel    = res_q.sel;
  assign dest_off    = res_q.off;

  // R1
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res_q));
  // R1
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R2
  not_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !present |-> fault_valid && fault_vec == VEC_W'(NP_VEC));
  // R4
  bad_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && gate_kind == GK_NONE |-> fault_valid);
  // R9
  copy_only_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && gate_kind != GK_CALL |-> copy_bytes == '0);
  // R10
  task_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && gate_kind == GK_TASK |-> dest_off == '0);
endmodule

// File: tb/gdv_top_tb.sv
module gdv_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] gate_desc = '0;
  logic [63:0] dest_desc = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        fault_valid;
  logic [7:0]  fault_vec;
  logic [2:0]  gate_kind;
  logic        present, legacy, push_wide;
  logic [6:0]  copy_bytes;
  logic [15:0] dest_sel;
  logic [31:0] dest_off;

  always #2.5 clk = ~clk;

  gdv_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .gate_desc(gate_desc), .dest_desc(dest_desc), .out_valid(out_valid),
    .out_ready(out_ready), .fault_valid(fault_valid), .fault_vec(fault_vec),
    .gate_kind(gate_kind), .present(present), .legacy(legacy),
    .push_wide(push_wide), .copy_bytes(copy_bytes), .dest_sel(dest_sel),
    .dest_off(dest_off)
  );

  typedef struct packed {
    logic        fv;
    logic [7:0]  vec;
    logic [2:0]  kind;
    logic        pres;
    logic        leg;
    logic        pw;
    logic [6:0]  cb;
    logic [15:0] sel;
    logic [31:0] off;
  } exp_t;

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];
  logic [63:0] sg[$];
  logic [63:0] sd[$];

  localparam logic [63:0] D_CODE = 64'h00CF_9A00_0000_FFFF;
  localparam logic [63:0] D_TSS  = 64'h0000_8900_0000_0067;
  localparam logic [63:0] D_BTSS = 64'h0000_8300_0000_002B;
  localparam logic [63:0] D_DATA = 64'h00CF_9200_0000_FFFF;
  localparam logic [63:0] D_LDT  = 64'h0000_8200_0000_00FF;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_gate(input logic p, input logic s, input logic [3:0] t,
                                          input logic [4:0] wc, input logic [15:0] sel,
                                          input logic [31:0] off);
    return {off[31:16], p, 2'b00, s, t, 3'b000, wc, sel, off[15:0]};
  endfunction

  function automatic exp_t model(input logic [63:0] g, input logic [63:0] d);
    exp_t e;
    int   k;
    int   wc;
    logic code_ok, tss_ok;
    e = '0;
    case (int'(g[43:40]))
      4, 12:   k = 1;
      6, 14:   k = 2;
      7, 15:   k = 3;
      5:       k = 4;
      default: k = 0;
    endcase
    e.kind = 3'(k);
    e.pres = g[47];
    e.leg  = (g[63:48] == 16'd0);
    e.pw   = g[43];
    wc     = int'(g[36:32]);
    e.cb   = (k == 1) ? 7'(wc * (e.leg ? 2 : 4)) : 7'd0;
    e.sel  = g[31:16];
    e.off  = (k == 4) ? 32'd0 : {g[63:48], g[15:0]};
    code_ok = d[44] && d[43];
    tss_ok  = !d[44] && (d[43:40] == 4'd1 || d[43:40] == 4'd3 ||
                         d[43:40] == 4'd9 || d[43:40] == 4'd11);
    e.fv = 1'b1;
    if (!g[47])                          e.vec = 8'd11;
    else if (g[44])                      e.vec = 8'd13;
    else if (k == 0)                     e.vec = 8'd13;
    else if (k == 4 ? !tss_ok : !code_ok) e.vec = 8'd13;
    else begin
      e.fv  = 1'b0;
      e.vec = 8'd0;
    end
    return e;
  endfunction

  task automatic add(input logic [63:0] g, input logic [63:0] d);
    sg.push_back(g);
    sd.push_back(d);
  endtask

  function automatic logic [63:0] pick_dest(input int r);
    case (r % 5)
      0: return D_CODE;
      1: return D_TSS;
      2: return D_BTSS;
      3: return D_DATA;
      default: return D_LDT;
    endcase
  endfunction

  initial begin
    int   cyc;
    int   idx;
    logic exp_ov;
    logic fire_in, fire_out;
    exp_t e;

    // directed beats
    add(mk_gate(1, 0, 4'hC, 5'd3,  16'h0010, 32'h1234_5678), D_CODE);  // R9 wide copy 12
    add(mk_gate(1, 0, 4'h4, 5'd5,  16'h0018, 32'h0000_1234), D_CODE);  // R7 R8 R9 legacy
    add(mk_gate(1, 0, 4'hE, 5'd0,  16'h0020, 32'h8000_0040), D_CODE);  // R4 interrupt
    add(mk_gate(1, 0, 4'h7, 5'd0,  16'h0028, 32'h0000_0100), D_CODE);  // R4 legacy trap
    add(mk_gate(1, 0, 4'h5, 5'd7,  16'h0030, 32'h0000_BEEF), D_TSS);   // R10 task off
    add(mk_gate(1, 0, 4'h5, 5'd0,  16'h0038, 32'h0000_0000), D_BTSS);  // R6 busy tss ok
    add(mk_gate(0, 1, 4'h0, 5'd2,  16'h0040, 32'h0000_0000), D_DATA);  // R2 priority
    add(mk_gate(1, 1, 4'hC, 5'd2,  16'h0048, 32'h0000_0000), D_CODE);  // R3
    add(mk_gate(1, 0, 4'h0, 5'd1,  16'h0050, 32'h0000_0000), D_CODE);  // R4 none
    add(mk_gate(1, 0, 4'hC, 5'd1,  16'h0058, 32'h0001_0000), D_DATA);  // R5 data dest
    add(mk_gate(1, 0, 4'h5, 5'd0,  16'h0060, 32'h0000_0000), D_CODE);  // R6 code dest
    add(mk_gate(1, 0, 4'hF, 5'd0,  16'h0068, 32'h0002_0000), D_TSS);   // R5 trap to tss
    add(mk_gate(1, 0, 4'hC, 5'd31, 16'h0070, 32'hFFFF_0000), D_CODE);  // R9 max 124
    add(mk_gate(1, 0, 4'h4, 5'd31, 16'h0078, 32'h0000_FFFF), D_CODE);  // R9 max 62
    for (int i = 0; i < 300; i++) begin
      logic [3:0] t;
      logic [31:0] off;
      t   = 4'($urandom_range(0, 15));
      off = ($urandom_range(0, 1) == 0) ? {16'd0, 16'($urandom)} : 32'($urandom);
      add(mk_gate(($urandom_range(0, 7) != 0), ($urandom_range(0, 7) == 0), t,
                  5'($urandom), 16'($urandom), off),
          pick_dest(int'($urandom_range(0, 4))));
    end

    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", 32'(out_valid), 32'd0);
    chk("R11 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    exp_ov = 1'b0;
    idx    = 0;
    cyc    = 0;
    while ((idx < sg.size() || q.size() != 0) && cyc < 50000) begin
      @(negedge clk);
      cyc++;
      // outputs after the last edge
      chk("R1 out_valid", 32'(out_valid), 32'(exp_ov));
      if (exp_ov) begin
        e = q[0];
        chk("R2 R3 R5 R6 R12 fault_valid", 32'(fault_valid), 32'(e.fv));
        chk("R2 R3 R4 R12 fault_vec", 32'(fault_vec), 32'(e.vec));
        chk("R4 gate_kind", 32'(gate_kind), 32'(e.kind));
        chk("R12 present", 32'(present), 32'(e.pres));
        chk("R7 legacy", 32'(legacy), 32'(e.leg));
        chk("R8 push_wide", 32'(push_wide), 32'(e.pw));
        chk("R9 copy_bytes", 32'(copy_bytes), 32'(e.cb));
        chk("R10 dest_sel", 32'(dest_sel), 32'(e.sel));
        chk("R10 dest_off", dest_off, e.off);
      end
      // drive next cycle
      out_ready = ($urandom_range(0, 9) < 7);
      if (idx < sg.size() && $urandom_range(0, 4) != 0) begin
        in_valid  = 1'b1;
        gate_desc = sg[idx];
        dest_desc = sd[idx];
      end else begin
        in_valid  = 1'b0;
        gate_desc = 64'($urandom) << 7;
        dest_desc = '0;
      end
      #1;
      chk("R1 in_ready", 32'(in_ready), 32'(!exp_ov || out_ready));
      fire_out = exp_ov && out_ready;
      fire_in  = in_valid && (!exp_ov || out_ready);
      if (fire_out) void'(q.pop_front());
      if (fire_in) begin
        q.push_back(model(sg[idx], sd[idx]));
        idx++;
      end
      exp_ov = (q.size() != 0);
    end
    if (cyc >= 50000) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual=%0d expected<%0d", cyc, 50000);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule